// File: doc/BRIEF.md
# Multicore Spin-Table Release Controller

This block holds a boot mailbox table for a cluster of processor cores, one 32-byte record per core. A boot core or firmware fills the records through a small register port with big-endian byte ordering, using byte, halfword or word accesses. Each record carries a 64-bit start address, a 64-bit argument, a 32-bit processor identifier and two reserved fields. A core stays held while bit 0 of its start address is 1.

A write can leave a record's start address with bit 0 cleared. When that happens the block raises a one-cycle, one-hot release pulse for that core. With the pulse it presents the launch values for the core. The entry point is the offset of the start address inside a fixed 64 MiB mapping window. It also gives the window base, the first argument, the window size and an encoded page-size code. At the same moment the record's identifier field is overwritten with the core's hardware ID, so software can see that the core was launched.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, record i holds start address 1, argument i and processor identifier i. Both reserved fields are zero.
- R2: Bits [9:5] of `bus_addr` select the record and bits [4:0] select the byte. `bus_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes. The offset's low bits below the access size are ignored. Bytes are big-endian: the lowest byte offset takes the most significant byte of the right-justified `bus_wdata`. A write changes only the addressed bytes. Field offsets inside a record: start address at 0..7, argument at 8..15, reserved word at 16..19, identifier at 20..23, reserved at 24..31.
- R3: A write aimed at record 0 changes nothing and never releases core 0.
- R4: A write is ignored when its record's `core_avail` bit is 0, or when `bus_size` is 3.
- R5: An accepted write that leaves bit 0 of the record's start address (byte offset 7, bit 0) at 0 makes `rel_pulse` equal to 1<<i in the cycle after the write, and zero in the cycle after that. Any other write leaves `rel_pulse` zero.
- R6: A later accepted write to a released record that still leaves bit 0 clear produces another pulse.
- R7: With a pulse, `rel_entry` is the start address masked to its low 26 bits, and `rel_win_base` is the start address with those 26 bits cleared.
- R8: With a pulse, `rel_arg` equals the record's argument, `rel_win_size` equals 0x4000000 and `rel_tsize` equals 8.
- R9: On release, the record's identifier field becomes HWID_BASE + i, and this value takes priority over any identifier bytes written in the same access.
- R10: A read returns the addressed bytes, big-endian and right-justified, on `rd_data` in the cycle after `bus_re`, with `rd_err` low.
- R11: A read with `bus_size` 3 returns zero and raises `rd_err` for that one result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_avail | input | NUM_CORES | One bit per present core |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address into the table |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Right-justified write data |
| rd_data | output | 32 | Read result, one cycle after the strobe |
| rd_err | output | 1 | Illegal read size flag |
| rel_pulse | output | NUM_CORES | One-hot release pulse |
| rel_entry | output | 64 | Entry point inside the window |
| rel_arg | output | 64 | First argument for the released core |
| rel_win_base | output | 64 | Window-aligned physical base |
| rel_win_size | output | 64 | Mapping window size in bytes |
| rel_tsize | output | 8 | Encoded page-size code |

## Verification
A wrong merge lane or a bad byte order appears on the next read of the same record, one cycle after the read strobe. If the bit-0 test reads the wrong lane, the failure appears sooner: `rel_pulse` is missing or spurious in the cycle right after the write. A record that was corrupted or not reset shows up through a read-back of its identifier and argument. An identifier that was not overwritten on launch shows up the same way. The random mix sends many writes to byte offsets 4 to 7, so releases and held cores alternate often. Each release is then compared against the split of the start address into window base and entry point.

// File: rtl/spin_tbl_pkg.sv
package spin_tbl_pkg;

   localparam int REC_BYTES = 32;
   localparam int REC_BITS  = REC_BYTES * 8;
   localparam int OFF_W     = 5;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   // last byte index covered by an access of this size, relative to its base
   function automatic logic [OFF_W-1:0] span_m1(acc_size_e sz);
      case (sz)
         SZ_BYTE: return 5'd0;
         SZ_HALF: return 5'd1;
         default: return 5'd3;
      endcase
   endfunction

   // page-size code: ((1-based lowest set bit of size>>10) - 1) >> 1
   function automatic int tsize_code(int win_log2);
      logic [63:0] s;
      int          low;
      s   = (64'd1 << win_log2) >> 10;
      low = 0;
      for (int b = 63; b >= 0; b--) begin
         if (s[b]) low = b + 1;
      end
      return (low - 1) >>> 1;
   endfunction

endpackage

// File: rtl/spin_wr_lane.sv
module spin_wr_lane
   import spin_tbl_pkg::*;
(
   input  logic [OFF_W-1:0]     off,
   input  acc_size_e            size,
   input  logic [31:0]          wdata,
   output logic [REC_BYTES-1:0] be,
   output logic [REC_BITS-1:0]  wbytes
);

   logic [OFF_W-1:0] len_m1;
   logic [OFF_W-1:0] base;

   always_comb begin
      len_m1 = span_m1(size);
      base   = off & ~len_m1;
   end

   for (genvar k = 0; k < REC_BYTES; k++) begin : g_lane
      localparam logic [OFF_W-1:0] KB = OFF_W'(k);
      logic [OFF_W-1:0] rel;
      logic [1:0]       sh;
      always_comb begin
         rel = KB - base;
         sh  = 2'(len_m1 - rel);
         be[k] = (size != SZ_BAD) && (KB >= base) && (KB <= base + len_m1);
         wbytes[REC_BITS-1-8*k -: 8] = wdata[{sh, 3'b000} +: 8];
      end
   end

endmodule

// File: rtl/spin_entry.sv
module spin_entry
   import spin_tbl_pkg::*;
#(
   parameter int          IDX  = 0,
   parameter logic [31:0] HWID = 32'h0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic [REC_BYTES-1:0] be,
   input  logic [REC_BITS-1:0]  wbytes,
   output logic [REC_BITS-1:0]  rec,
   output logic                 rel_req,
   output logic [63:0]          nxt_start,
   output logic [63:0]          nxt_arg
);

   // field slices, big-endian: byte 0 sits in the top bits
   localparam int START_LSB = REC_BITS - 64;
   localparam int ID_LSB    = REC_BITS - 8*24;

   localparam logic [REC_BITS-1:0] RST_REC =
      {64'd1, 64'(IDX), 32'd0, 32'(IDX), 64'd0};

   logic [REC_BITS-1:0] merged;
   logic [REC_BITS-1:0] final_rec;

   for (genvar k = 0; k < REC_BYTES; k++) begin : g_merge
      assign merged[REC_BITS-1-8*k -: 8] =
         be[k] ? wbytes[REC_BITS-1-8*k -: 8] : rec[REC_BITS-1-8*k -: 8];
   end

   always_comb begin
      rel_req   = sel && !merged[START_LSB];
      final_rec = merged;
      if (rel_req) final_rec[ID_LSB +: 32] = HWID;
      nxt_start = merged[START_LSB +: 64];
      nxt_arg   = merged[START_LSB-64 +: 64];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   rec <= RST_REC;
      else if (sel) rec <= final_rec;
   end

   // R9: a launched record shows its own hardware ID afterwards
   p_own_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rel_req |=> rec[ID_LSB +: 32] == HWID);

endmodule

// File: rtl/spin_rel_out.sv
module spin_rel_out
   import spin_tbl_pkg::*;
#(
   parameter int NUM_CORES = 32,
   parameter int WIN_LOG2  = 26,
   parameter int TSZ_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] req,
   input  logic [63:0]          start,
   input  logic [63:0]          arg,
   output logic [NUM_CORES-1:0] rel_pulse,
   output logic [63:0]          rel_entry,
   output logic [63:0]          rel_arg,
   output logic [63:0]          rel_win_base,
   output logic [63:0]          rel_win_size,
   output logic [TSZ_W-1:0]     rel_tsize
);

   localparam logic [63:0]      WIN_SIZE = 64'd1 << WIN_LOG2;
   localparam logic [63:0]      WIN_MASK = WIN_SIZE - 64'd1;
   localparam logic [TSZ_W-1:0] TSZ      = TSZ_W'(tsize_code(WIN_LOG2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel_pulse    <= '0;
         rel_entry    <= '0;
         rel_arg      <= '0;
         rel_win_base <= '0;
         rel_win_size <= '0;
         rel_tsize    <= '0;
      end else begin
         rel_pulse <= req;
         if (|req) begin
            rel_entry    <= start & WIN_MASK;
            rel_win_base <= start & ~WIN_MASK;
            rel_arg      <= arg;
            rel_win_size <= WIN_SIZE;
            rel_tsize    <= TSZ;
         end
      end
   end

   // R5: never more than one core launched at a time
   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rel_pulse));

   // R7: window base and entry offset never overlap
   p_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|rel_pulse) |-> ((rel_entry & rel_win_base) == 64'd0));

endmodule

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl
   import spin_tbl_pkg::*;
#(
   parameter int          NUM_CORES = 32,
   parameter int          WIN_LOG2  = 26,
   parameter logic [31:0] HWID_BASE = 32'h100,
   parameter int          TSZ_W     = 8,
   localparam int         IW        = $clog2(NUM_CORES),
   localparam int         AW        = IW + OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] core_avail,
   input  logic                 bus_we,
   input  logic                 bus_re,
   input  logic [AW-1:0]        bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          rd_data,
   output logic                 rd_err,
   output logic [NUM_CORES-1:0] rel_pulse,
   output logic [63:0]          rel_entry,
   output logic [63:0]          rel_arg,
   output logic [63:0]          rel_win_base,
   output logic [63:0]          rel_win_size,
   output logic [TSZ_W-1:0]     rel_tsize
);

   if (NUM_CORES < 2 || NUM_CORES > 64) begin : g_bad_cores
      $error("NUM_CORES must lie in 2..64");
   end
   if (WIN_LOG2 < 12 || WIN_LOG2 > 62) begin : g_bad_win
      $error("WIN_LOG2 must lie in 12..62");
   end

   acc_size_e        sz;
   logic [IW-1:0]    idx;
   logic [OFF_W-1:0] off;
   logic             idx_ok;
   logic             accept;

   always_comb begin
      sz     = acc_size_e'(bus_size);
      idx    = bus_addr[AW-1:OFF_W];
      off    = bus_addr[OFF_W-1:0];
      idx_ok = 32'(idx) < NUM_CORES;
      accept = bus_we && idx_ok && (idx != '0) && (sz != SZ_BAD)
               && core_avail[idx];
   end

   logic [REC_BYTES-1:0] be;
   logic [REC_BITS-1:0]  wbytes;

   spin_wr_lane u_lane (
      .off    (off),
      .size   (sz),
      .wdata  (bus_wdata),
      .be     (be),
      .wbytes (wbytes)
   );

   logic [REC_BITS-1:0]  rec_a   [NUM_CORES];
   logic [63:0]          start_a [NUM_CORES];
   logic [63:0]          arg_a   [NUM_CORES];
   logic [NUM_CORES-1:0] req;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_rec
      logic sel_i;
      assign sel_i = accept && (32'(idx) == i);
      spin_entry #(
         .IDX  (i),
         .HWID (HWID_BASE + 32'(i))
      ) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel       (sel_i),
         .be        (be),
         .wbytes    (wbytes),
         .rec       (rec_a[i]),
         .rel_req   (req[i]),
         .nxt_start (start_a[i]),
         .nxt_arg   (arg_a[i])
      );
   end

   logic [63:0] sel_start;
   logic [63:0] sel_arg;

   always_comb begin
      sel_start = '0;
      sel_arg   = '0;
      if (idx_ok) begin
         sel_start = start_a[idx];
         sel_arg   = arg_a[idx];
      end
   end

   spin_rel_out #(
      .NUM_CORES (NUM_CORES),
      .WIN_LOG2  (WIN_LOG2),
      .TSZ_W     (TSZ_W)
   ) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .start        (sel_start),
      .arg          (sel_arg),
      .rel_pulse    (rel_pulse),
      .rel_entry    (rel_entry),
      .rel_arg      (rel_arg),
      .rel_win_base (rel_win_base),
      .rel_win_size (rel_win_size),
      .rel_tsize    (rel_tsize)
   );

   // read path
   logic [REC_BITS-1:0] rd_rec;
   logic [OFF_W-1:0]    rbase;
   logic [7:0]          rb [4];
   logic [31:0]         rd_word;

   always_comb begin
      rd_rec = idx_ok ? rec_a[idx] : '0;
      rbase  = off & ~span_m1(sz);
      for (int j = 0; j < 4; j++) begin
         logic [REC_BITS-1:0] tmp;
         tmp   = rd_rec << {rbase + OFF_W'(j), 3'b000};
         rb[j] = tmp[REC_BITS-1 -: 8];
      end
      case (sz)
         SZ_BYTE: rd_word = {24'd0, rb[0]};
         SZ_HALF: rd_word = {16'd0, rb[0], rb[1]};
         SZ_WORD: rd_word = {rb[0], rb[1], rb[2], rb[3]};
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_err  <= 1'b0;
      end else begin
         rd_err <= bus_re && (sz == SZ_BAD);
         if (bus_re) rd_data <= rd_word;
      end
   end

   // R5: a pulse always follows a write strobe
   p_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|rel_pulse) |-> $past(bus_we));

   // R5: the pulse names the core that was addressed
   p_names_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|rel_pulse) |-> (rel_pulse == (NUM_CORES'(1) << $past(idx))));

   // R3: the primary core is never launched
   p_core0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_pulse[0]);

   // R11: an illegal read yields zero data
   p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (rd_data == 32'd0) && $past(bus_re));

   // R4: an illegal-size write never launches a core
   p_bad_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_size == 2'd3) |=> (rel_pulse == '0));

endmodule

// File: tb/tb_spin_release_ctrl.sv
module tb_spin_release_ctrl;

   localparam int          CLK_PERIOD = 10;
   localparam int          NC         = 32;
   localparam logic [31:0] HWB        = 32'h100;
   localparam logic [63:0] WMASK      = 64'h3FF_FFFF;
   localparam logic [NC-1:0] AVAIL    = 32'h7FFF_FFDF; // cores 5 and 31 absent

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NC-1:0] core_avail = AVAIL;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_data;
   logic        rd_err;
   logic [NC-1:0] rel_pulse;
   logic [63:0] rel_entry, rel_arg, rel_win_base, rel_win_size;
   logic [7:0]  rel_tsize;

   spin_release_ctrl dut (
      .clk(clk), .rst_n(rst_n), .core_avail(core_avail),
      .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata),
      .rd_data(rd_data), .rd_err(rd_err), .rel_pulse(rel_pulse),
      .rel_entry(rel_entry), .rel_arg(rel_arg), .rel_win_base(rel_win_base),
      .rel_win_size(rel_win_size), .rel_tsize(rel_tsize)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [7:0] m [NC][32];

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] m_start(int c);
      logic [63:0] v = '0;
      for (int j = 0; j < 8; j++) v = {v[55:0], m[c][j]};
      return v;
   endfunction

   function automatic logic [63:0] m_arg(int c);
      logic [63:0] v = '0;
      for (int j = 8; j < 16; j++) v = {v[55:0], m[c][j]};
      return v;
   endfunction

   function automatic int len_of(logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < NC; c++) begin
         for (int j = 0; j < 32; j++) m[c][j] = 8'h00;
         m[c][7]  = 8'h01;
         m[c][15] = 8'(c);
         m[c][23] = 8'(c);
      end
   endtask

   // R2 R3 R4 R5 R6 R7 R8 R9
   task automatic do_write(int a, logic [1:0] sz, logic [31:0] d);
      int c = a / 32, off = a % 32, len, base, rel = -1;
      logic [63:0] st;
      @(negedge clk);
      bus_addr = 10'(a); bus_size = sz; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      if (sz != 2'd3 && c != 0 && AVAIL[c]) begin
         len  = len_of(sz);
         base = off & ~(len - 1);
         for (int j = 0; j < len; j++) m[c][base+j] = 8'(d >> (8*(len-1-j)));
         if (m[c][7][0] == 1'b0) begin
            rel = c;
            for (int j = 0; j < 4; j++)
               m[c][20+j] = 8'((HWB + 32'(c)) >> (8*(3-j)));
         end
      end
      if (rel >= 0) begin
         st = m_start(rel);
         chk("R5 pulse", 64'(rel_pulse), 64'(32'd1 << rel));
         chk("R7 entry", rel_entry, st & WMASK);
         chk("R7 base", rel_win_base, st & ~WMASK);
         chk("R8 arg", rel_arg, m_arg(rel));
         chk("R8 size", rel_win_size, 64'h400_0000);
         chk("R8 tsize", 64'(rel_tsize), 64'd8);
         @(negedge clk);
         chk("R5 single cycle", 64'(rel_pulse), 64'd0);
      end else begin
         chk("R5/R3/R4 no pulse", 64'(rel_pulse), 64'd0);
      end
   endtask

   // R10 R11
   task automatic do_read(int a, logic [1:0] sz);
      int c = a / 32, off = a % 32, len, base;
      logic [31:0] exp = '0;
      @(negedge clk);
      bus_addr = 10'(a); bus_size = sz; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      if (sz == 2'd3) begin
         chk("R11 data", 64'(rd_data), 64'd0);
         chk("R11 err", 64'(rd_err), 64'd1);
      end else begin
         len  = len_of(sz);
         base = off & ~(len - 1);
         for (int j = 0; j < len; j++) exp = {exp[23:0], m[c][base+j]};
         chk("R10 data", 64'(rd_data), 64'(exp));
         chk("R10 err", 64'(rd_err), 64'd0);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset contents
      chk("R1 pulse idle", 64'(rel_pulse), 64'd0);
      for (int c = 0; c < NC; c += 7) begin
         do_read(c*32 + 20, 2'd2);   // R1 identifier
         do_read(c*32 + 12, 2'd2);   // R1 argument low word
         do_read(c*32 + 4, 2'd2);    // R1 start low word
         do_read(c*32 + 0, 2'd2);
         do_read(c*32 + 28, 2'd2);
      end
      // R3: core 0 writes ignored
      do_write(0*32 + 4, 2'd2, 32'h0);
      do_read(0*32 + 4, 2'd2);
      // R4: absent core and illegal size ignored
      do_write(5*32 + 4, 2'd2, 32'h0);
      do_read(5*32 + 4, 2'd2);
      do_write(2*32 + 4, 2'd3, 32'h0);
      do_read(2*32 + 4, 2'd2);
      // R2: high word write keeps the core held
      do_write(2*32 + 0, 2'd2, 32'h1234_5678);
      do_read(2*32 + 0, 2'd2);
      // R5 R7 R8 R9: release core 2
      do_write(2*32 + 4, 2'd2, 32'h0ABC_DEF0);
      do_read(2*32 + 20, 2'd2);          // R9 identifier = 0x102
      // R6: second release with a byte write
      do_write(2*32 + 7, 2'd0, 32'h22);
      // R9: identifier write in a releasing record loses to the hardware ID
      do_write(2*32 + 20, 2'd2, 32'hDEAD_BEEF);
      do_read(2*32 + 20, 2'd2);
      // R2: halfword, misaligned halfword, byte lanes
      do_write(3*32 + 10, 2'd1, 32'hBEEF);
      do_write(3*32 + 13, 2'd1, 32'hCAFE);
      do_read(3*32 + 8, 2'd2);
      do_read(3*32 + 12, 2'd2);
      do_read(3*32 + 11, 2'd0);
      do_read(3*32 + 9, 2'd1);
      // R11: illegal read size
      do_read(3*32 + 8, 2'd3);
      // R5: highest present core and release to core 30
      do_write(30*32 + 7, 2'd0, 32'hFE);
      do_write(31*32 + 7, 2'd0, 32'hFE);
      // random mix
      for (int it = 0; it < 1500; it++) begin
         int c   = int'($urandom % NC);
         int off = ($urandom % 2 == 0) ? 4 + int'($urandom % 4) : int'($urandom % 32);
         logic [1:0] sz = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
         if ($urandom % 2 == 0) do_write(c*32 + off, sz, $urandom);
         else                   do_read(c*32 + off, sz);
      end
      finish_run();
   end

endmodule